// File: doc/BRIEF.md
# Vectored Interrupt Priority Core

This block keeps the per-vector interrupt bookkeeping for one processor. There are 256 vectors. For each one the core holds a pending flag, an in-service flag and a trigger-mode flag. Interrupt sources post a vector together with its trigger type. The core ranks vectors by number, where a higher number means higher priority, and groups them into 16 priority classes taken from the upper nibble of the vector. It then decides whether the processor should be interrupted.

The processor interacts with the core through a few ports:
- It sets a task priority.
- It enables the core through a spurious/enable register.
- It acknowledges a request to learn which vector to service.
- It signals end-of-interrupt to retire the most urgent in-service vector.

The processor priority is derived from the task priority and the in-service state, and it can be read back. A counter of posts that found their vector not yet pending lets coalesced interrupts be measured.

Top module: `vipc_core`

## Requirements
- R1: After reset the task priority reads 0, the spurious register reads 0x0FF (enable bit 8 clear), the pending, in-service and trigger-mode arrays are all zero, the request output is 0 and the new-post counter is 0.
- R2: A post sets the pending bit of its vector. It sets that vector's trigger-mode bit when `post_level` is 1 (level) and clears it when `post_level` is 0 (edge).
- R3: The processor priority readback works as follows. Let C be bits 7:4 of the highest set in-service vector, or 0 when none is set. If task-priority bits 7:4 are greater than or equal to C, the readback equals the full task priority. Otherwise it equals C shifted left by 4.
- R4: The request is 1 only when all three conditions hold: spurious bit 8 is 1, at least one vector is pending, and either the processor priority is 0 or bits 7:4 of the highest pending vector are strictly greater than bits 7:4 of the processor priority.
- R5: An acknowledge that is not spurious clears the highest pending bit and sets the same bit in service. One cycle later it returns that vector with `ack_valid` high.
- R6: An acknowledge is spurious in two cases: the pending array is empty, or the task priority is non-zero and the highest pending vector is numerically less than or equal to it. A spurious acknowledge returns spurious bits 7:0 and changes no array.
- R7: End-of-interrupt clears the highest set in-service bit. It has no effect when no in-service bit is set.
- R8: A spurious-register write keeps bits 8:0 of `reg_wdata`. A task-priority write keeps bits 7:0.
- R9: A post and an acknowledge in the same cycle both take effect. The acknowledge uses the state from before the post, and the posted bit is set after the edge even if it is the acknowledged vector.
- R10: `post_new_cnt` increments by one for each post whose pending bit was clear before that post. A post to an already pending vector leaves it unchanged.
- R11: The request output is registered. It reflects the state that results from a stimulus one clock edge after that state appears on the array and register outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| post_valid | input | 1 | Post a vector this cycle |
| post_vec | input | 8 | Vector being posted |
| post_level | input | 1 | 1 = level-triggered post, 0 = edge |
| ack_req | input | 1 | Processor acknowledge strobe |
| ack_valid | output | 1 | Acknowledge result valid (one cycle after ack_req) |
| ack_vec | output | 8 | Accepted or spurious vector |
| eoi | input | 1 | End-of-interrupt strobe |
| reg_wdata | input | 32 | Write data for the register ports |
| tpr_we | input | 1 | Write task priority |
| svr_we | input | 1 | Write spurious/enable register |
| tpr_q | output | 8 | Task priority readback |
| svr_q | output | 9 | Spurious/enable register readback |
| ppr_q | output | 8 | Processor priority readback |
| irq | output | 1 | Registered interrupt request to the processor |
| irr_bits | output | 256 | Pending array |
| isr_bits | output | 256 | In-service array |
| tmr_bits | output | 256 | Trigger-mode array |
| post_new_cnt | output | 32 | Count of posts that found their vector not pending |

## Verification
Each stimulus (post, acknowledge, end-of-interrupt or register write) is captured at one clock edge. The arrays, the register readbacks, the processor priority, the counter and the acknowledge result are due right after that edge. The request output lags one more edge, because it is registered from that state.

The bench drives stimulus at falling edges and compares at the next falling edge. Its reference model is updated in the same step. For the request it keeps the value predicted from the previous step's state, so that it compares the request against the state from two falling edges earlier. Same-cycle post with acknowledge, and same-cycle acknowledge with a register write, are resolved in the model from the state before the edge.

// File: rtl/vipc_pkg.sv
package vipc_pkg;
   typedef enum logic {
      TRIG_EDGE  = 1'b0,
      TRIG_LEVEL = 1'b1
   } trig_e;

   // priority class of a vector: bits above the class shift
   function automatic int unsigned class_of(input int unsigned v, input int unsigned sh);
      return v >> sh;
   endfunction
endpackage

// File: rtl/vipc_hi_enc.sv
module vipc_hi_enc #(
   parameter int N      = 256,
   parameter int WORD_W = 32
) (
   input  logic [N-1:0]         bits,
   output logic                 any,
   output logic [$clog2(N)-1:0] idx
);
   localparam int IW = $clog2(N);
   localparam int NW = N / WORD_W;
   localparam int BW = $clog2(WORD_W);

   initial begin
      if (N % WORD_W != 0) $error("vipc_hi_enc: N must be a multiple of WORD_W");
      if (WORD_W < 2 || (1 << BW) != WORD_W) $error("vipc_hi_enc: WORD_W must be a power of two");
   end

   logic [NW-1:0] word_hit;
   logic [BW-1:0] word_loc [NW];

   genvar w;
   generate
      for (w = 0; w < NW; w++) begin : g_word
         logic [BW-1:0] loc;
         logic          hit;
         always_comb begin
            loc = '0;
            hit = 1'b0;
            for (int b = 0; b < WORD_W; b++) begin
               if (bits[w*WORD_W + b]) begin
                  loc = BW'(b);
                  hit = 1'b1;
               end
            end
         end
         assign word_hit[w] = hit;
         assign word_loc[w] = loc;
      end
   endgenerate

   always_comb begin
      any = 1'b0;
      idx = '0;
      for (int k = 0; k < NW; k++) begin
         if (word_hit[k]) begin
            any = 1'b1;
            idx = IW'(k * WORD_W) | IW'(word_loc[k]);
         end
      end
   end
endmodule

// File: rtl/vipc_ppr.sv
module vipc_ppr #(
   parameter int VEC_W     = 8,
   parameter int CLS_SHIFT = 4
) (
   input  logic [VEC_W-1:0] tpr,
   input  logic             isr_any,
   input  logic [VEC_W-1:0] isr_hi,
   output logic [VEC_W-1:0] ppr
);
   localparam int CLS_W = VEC_W - CLS_SHIFT;

   initial begin
      if (CLS_SHIFT < 1 || CLS_SHIFT >= VEC_W) $error("vipc_ppr: CLS_SHIFT out of range");
   end

   logic [CLS_W-1:0] isr_cls;
   logic [CLS_W-1:0] tpr_cls;

   assign isr_cls = isr_any ? isr_hi[VEC_W-1:CLS_SHIFT] : '0;
   assign tpr_cls = tpr[VEC_W-1:CLS_SHIFT];

   always_comb begin
      if (tpr_cls >= isr_cls) ppr = tpr;
      else                    ppr = {isr_cls, {CLS_SHIFT{1'b0}}};
   end
endmodule

// File: rtl/vipc_core.sv
module vipc_core #(
   parameter int NUM_VEC   = 256,
   parameter int WORD_W    = 32,
   parameter int CLS_SHIFT = 4,
   parameter int REG_W     = 32,
   parameter int CNT_W     = 32
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         post_valid,
   input  logic [$clog2(NUM_VEC)-1:0]   post_vec,
   input  logic                         post_level,
   input  logic                         ack_req,
   output logic                         ack_valid,
   output logic [$clog2(NUM_VEC)-1:0]   ack_vec,
   input  logic                         eoi,
   input  logic [REG_W-1:0]             reg_wdata,
   input  logic                         tpr_we,
   input  logic                         svr_we,
   output logic [$clog2(NUM_VEC)-1:0]   tpr_q,
   output logic [$clog2(NUM_VEC):0]     svr_q,
   output logic [$clog2(NUM_VEC)-1:0]   ppr_q,
   output logic                         irq,
   output logic [NUM_VEC-1:0]           irr_bits,
   output logic [NUM_VEC-1:0]           isr_bits,
   output logic [NUM_VEC-1:0]           tmr_bits,
   output logic [CNT_W-1:0]             post_new_cnt
);
   import vipc_pkg::*;

   localparam int VEC_W = $clog2(NUM_VEC);
   localparam int SVR_W = VEC_W + 1;
   localparam int CLS_W = VEC_W - CLS_SHIFT;
   localparam logic [SVR_W-1:0] SVR_RST = {1'b0, {VEC_W{1'b1}}};

   initial begin
      if ((1 << VEC_W) != NUM_VEC) $error("vipc_core: NUM_VEC must be a power of two");
      if (REG_W < SVR_W) $error("vipc_core: REG_W too narrow for the spurious register");
      if (CNT_W < 1) $error("vipc_core: CNT_W must be positive");
   end

   // architectural state
   logic [NUM_VEC-1:0] irr_r, isr_r, tmr_r;
   logic [VEC_W-1:0]   tpr_r;
   logic [SVR_W-1:0]   svr_r;
   logic [CNT_W-1:0]   cnt_r;
   logic               irq_r;
   logic               ackv_r;
   logic [VEC_W-1:0]   ackvec_r;

   // priority encoders
   logic             irr_any, isr_any;
   logic [VEC_W-1:0] irr_hi, isr_hi;
   logic [VEC_W-1:0] ppr;

   vipc_hi_enc #(.N(NUM_VEC), .WORD_W(WORD_W)) u_enc_irr (
      .bits(irr_r), .any(irr_any), .idx(irr_hi));
   vipc_hi_enc #(.N(NUM_VEC), .WORD_W(WORD_W)) u_enc_isr (
      .bits(isr_r), .any(isr_any), .idx(isr_hi));
   vipc_ppr #(.VEC_W(VEC_W), .CLS_SHIFT(CLS_SHIFT)) u_ppr (
      .tpr(tpr_r), .isr_any(isr_any), .isr_hi(isr_hi), .ppr(ppr));

   // request decision on the current state
   logic irq_d;
   logic [CLS_W-1:0] irr_cls, ppr_cls;
   assign irr_cls = irr_hi[VEC_W-1:CLS_SHIFT];
   assign ppr_cls = ppr[VEC_W-1:CLS_SHIFT];
   assign irq_d   = svr_r[SVR_W-1] && irr_any && ((ppr == '0) || (irr_cls > ppr_cls));

   // acknowledge classification
   logic ack_spur, ack_take;
   assign ack_spur = !irr_any || ((tpr_r != '0) && (irr_hi <= tpr_r));
   assign ack_take = ack_req && !ack_spur;

   // next-state arrays: end-of-interrupt clear, then acknowledge move, then post
   logic [NUM_VEC-1:0] irr_n, isr_n, tmr_n;
   always_comb begin
      isr_n = isr_r;
      irr_n = irr_r;
      tmr_n = tmr_r;
      if (eoi && isr_any) isr_n[isr_hi] = 1'b0;
      if (ack_take) begin
         isr_n[irr_hi] = 1'b1;
         irr_n[irr_hi] = 1'b0;
      end
      if (post_valid) begin
         irr_n[post_vec] = 1'b1;
         tmr_n[post_vec] = (trig_e'(post_level) == TRIG_LEVEL);
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         irr_r    <= '0;
         isr_r    <= '0;
         tmr_r    <= '0;
         tpr_r    <= '0;
         svr_r    <= SVR_RST;
         cnt_r    <= '0;
         irq_r    <= 1'b0;
         ackv_r   <= 1'b0;
         ackvec_r <= '0;
      end else begin
         irr_r  <= irr_n;
         isr_r  <= isr_n;
         tmr_r  <= tmr_n;
         irq_r  <= irq_d;
         ackv_r <= ack_req;
         if (ack_req) ackvec_r <= ack_spur ? svr_r[VEC_W-1:0] : irr_hi;
         if (tpr_we)  tpr_r <= reg_wdata[VEC_W-1:0];
         if (svr_we)  svr_r <= reg_wdata[SVR_W-1:0];
         if (post_valid && !irr_r[post_vec]) cnt_r <= cnt_r + 1'b1;
      end
   end

   assign ack_valid    = ackv_r;
   assign ack_vec      = ackvec_r;
   assign tpr_q        = tpr_r;
   assign svr_q        = svr_r;
   assign ppr_q        = ppr;
   assign irq          = irq_r;
   assign irr_bits     = irr_r;
   assign isr_bits     = isr_r;
   assign tmr_bits     = tmr_r;
   assign post_new_cnt = cnt_r;
endmodule

// File: rtl/vipc_core_chk.sv
module vipc_core_chk #(
   parameter int NUM_VEC = 256,
   parameter int CNT_W   = 32
) (
   input logic                       clk,
   input logic                       rst_n,
   input logic                       post_valid,
   input logic [$clog2(NUM_VEC)-1:0] post_vec,
   input logic                       post_level,
   input logic                       ack_req,
   input logic                       ack_valid,
   input logic [$clog2(NUM_VEC)-1:0] ack_vec,
   input logic                       eoi,
   input logic [$clog2(NUM_VEC):0]   svr_q,
   input logic                       irq,
   input logic [NUM_VEC-1:0]         irr_bits,
   input logic [NUM_VEC-1:0]         isr_bits,
   input logic [NUM_VEC-1:0]         tmr_bits,
   input logic [CNT_W-1:0]           post_new_cnt
);
   localparam int VEC_W = $clog2(NUM_VEC);

   a_r2_post_sets_pending: assert property (@(posedge clk) disable iff (!rst_n)
      post_valid |=> irr_bits[$past(post_vec)]);

   a_r2_post_trigger_mode: assert property (@(posedge clk) disable iff (!rst_n)
      post_valid |=> (tmr_bits[$past(post_vec)] == $past(post_level)));

   a_r4_irq_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> $past(svr_q[VEC_W]));

   a_r4_irq_needs_pending: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> $past(|irr_bits));

   a_r5_ack_lands_in_service: assert property (@(posedge clk) disable iff (!rst_n)
      ack_valid |-> (isr_bits[ack_vec] || (ack_vec == $past(svr_q[VEC_W-1:0]))));

   a_r7_eoi_retires_one: assert property (@(posedge clk) disable iff (!rst_n)
      (eoi && (|isr_bits) && !ack_req) |=> ($countones(isr_bits) == $countones($past(isr_bits)) - 1));

   a_r10_count_step: assert property (@(posedge clk) disable iff (!rst_n)
      (post_new_cnt - $past(post_new_cnt)) <= CNT_W'(1));
endmodule

bind vipc_core vipc_core_chk #(.NUM_VEC(NUM_VEC), .CNT_W(CNT_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .post_valid(post_valid), .post_vec(post_vec),
   .post_level(post_level), .ack_req(ack_req), .ack_valid(ack_valid),
   .ack_vec(ack_vec), .eoi(eoi), .svr_q(svr_q), .irq(irq),
   .irr_bits(irr_bits), .isr_bits(isr_bits), .tmr_bits(tmr_bits),
   .post_new_cnt(post_new_cnt));

// File: tb/tb_vipc_core.sv
`timescale 1ns/1ps
module tb_vipc_core;
   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         post_valid = 1'b0;
   logic [7:0]   post_vec = '0;
   logic         post_level = 1'b0;
   logic         ack_req = 1'b0;
   logic         ack_valid;
   logic [7:0]   ack_vec;
   logic         eoi = 1'b0;
   logic [31:0]  reg_wdata = '0;
   logic         tpr_we = 1'b0;
   logic         svr_we = 1'b0;
   logic [7:0]   tpr_q;
   logic [8:0]   svr_q;
   logic [7:0]   ppr_q;
   logic         irq;
   logic [255:0] irr_bits, isr_bits, tmr_bits;
   logic [31:0]  post_new_cnt;

   always #4 clk = ~clk;   // 125 MHz

   vipc_core dut (.*);

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   // reference model
   logic [255:0] m_irr = '0, m_isr = '0, m_tmr = '0;
   logic [7:0]   m_tpr = '0;
   logic [8:0]   m_svr = 9'h0FF;
   logic [31:0]  m_cnt = '0;
   bit           e_irq = 1'b0;
   bit           e_ackv = 1'b0;
   logic [7:0]   e_ackvec = '0;
   string        phase = "";

   function automatic int hi(input logic [255:0] a);
      int r = -1;
      for (int i = 0; i < 256; i++) if (a[i]) r = i;
      return r;
   endfunction

   function automatic logic [7:0] m_ppr();
      int h = hi(m_isr);
      int c = (h < 0) ? 0 : (h >> 4);
      if (int'(m_tpr >> 4) >= c) return m_tpr;
      return 8'(c << 4);
   endfunction

   function automatic bit m_req();
      int h = hi(m_irr);
      logic [7:0] p = m_ppr();
      if (!m_svr[8] || h < 0) return 1'b0;
      return (p == 0) || ((h >> 4) > int'(p >> 4));
   endfunction

   task automatic chk(input string tag, input logic [255:0] act, input logic [255:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s [%s] actual=%0h expected=%0h", tag, phase, act, exp);
      end
   endtask

   task automatic compare_all();
      chk("R2 pending", irr_bits, m_irr);
      chk("R2 trigger", tmr_bits, m_tmr);
      chk("R5 R7 in-service", isr_bits, m_isr);
      chk("R3 ppr", 256'(ppr_q), 256'(m_ppr()));
      chk("R8 tpr", 256'(tpr_q), 256'(m_tpr));
      chk("R8 svr", 256'(svr_q), 256'(m_svr));
      chk("R10 count", 256'(post_new_cnt), 256'(m_cnt));
      chk("R4 R11 irq", 256'(irq), 256'(e_irq));
      chk("R5 R6 ack_valid", 256'(ack_valid), 256'(e_ackv));
      if (e_ackv) chk("R5 R6 ack_vec", 256'(ack_vec), 256'(e_ackvec));
   endtask

   task automatic step(input bit pv, input logic [7:0] pvec, input bit plvl, input bit ak,
                       input bit eo, input bit twe, input bit swe, input logic [31:0] wd);
      int hirr, hisr;
      bit spur;
      @(negedge clk);
      compare_all();
      e_irq = m_req();            // request due one edge after this state
      post_valid = pv; post_vec = pvec; post_level = plvl;
      ack_req = ak; eoi = eo; tpr_we = twe; svr_we = swe; reg_wdata = wd;
      hirr = hi(m_irr);
      hisr = hi(m_isr);
      spur = (hirr < 0) || ((m_tpr != 0) && (hirr <= int'(m_tpr)));
      e_ackv = ak;
      if (ak) e_ackvec = spur ? m_svr[7:0] : 8'(hirr);
      if (eo && hisr >= 0) m_isr[hisr] = 1'b0;
      if (ak && !spur) begin
         m_isr[hirr] = 1'b1;
         m_irr[hirr] = 1'b0;
      end
      if (pv) begin
         if (hi_bit(pvec)) ; else m_cnt++;
         m_irr[pvec] = 1'b1;
         m_tmr[pvec] = plvl;
      end
      if (twe) m_tpr = wd[7:0];
      if (swe) m_svr = wd[8:0];
   endtask

   // pending bit of the model before the current step's updates are applied
   logic [255:0] pre_irr;
   function automatic bit hi_bit(input logic [7:0] v);
      return pre_irr[v];
   endfunction

   task automatic go(input bit pv, input logic [7:0] pvec, input bit plvl, input bit ak,
                     input bit eo, input bit twe, input bit swe, input logic [31:0] wd);
      pre_irr = m_irr;
      step(pv, pvec, plvl, ak, eo, twe, swe, wd);
   endtask

   task automatic idle();
      go(0, 8'h0, 0, 0, 0, 0, 0, 32'h0);
   endtask

   initial begin
      void'($urandom(32'h5eed_1234));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1: reset state
      phase = "R1 reset";
      @(negedge clk);
      chk("R1 tpr", 256'(tpr_q), 256'h0);
      chk("R1 svr", 256'(svr_q), 256'h0FF);
      chk("R1 arrays", irr_bits | isr_bits | tmr_bits, 256'h0);
      chk("R1 irq", 256'(irq), 256'h0);
      chk("R1 count", 256'(post_new_cnt), 256'h0);

      // R8: only 9 bits kept; disabled core raises no request
      phase = "R8 width";
      go(0, 0, 0, 0, 0, 1, 1, 32'hFFFF_FE37);
      go(1, 8'h45, 0, 0, 0, 0, 0, 32'h0);          // R2 edge post, disabled
      idle(); idle();
      phase = "R8 enable";
      go(0, 0, 0, 0, 0, 1, 1, 32'h0000_01F0);      // tpr=F0 svr=1F0
      idle(); idle();
      // R4: tpr class F masks request; lower tpr raises it (R11 one edge later)
      phase = "R4 R11 tpr drop";
      go(0, 0, 0, 0, 0, 1, 0, 32'h0000_0000);
      idle(); idle();
      phase = "R2 level";
      go(1, 8'h46, 1, 0, 0, 0, 0, 32'h0);
      idle();
      phase = "R5 ack";
      go(0, 0, 0, 1, 0, 0, 0, 32'h0);              // returns 0x46
      idle(); idle();
      phase = "R6 masked ack";
      go(0, 0, 0, 0, 0, 1, 0, 32'h0000_0050);
      go(0, 0, 0, 1, 0, 0, 0, 32'h0);              // 0x45 <= 0x50 -> spurious F0
      idle();
      phase = "R6 equal ack";
      go(0, 0, 0, 0, 0, 1, 0, 32'h0000_0045);
      go(0, 0, 0, 1, 0, 0, 0, 32'h0);              // 0x45 <= 0x45 -> spurious
      idle();
      phase = "R7 eoi";
      go(0, 0, 0, 0, 1, 0, 0, 32'h0);
      go(0, 0, 0, 0, 1, 0, 0, 32'h0);              // empty: no effect
      idle();
      phase = "R9 post+ack";
      go(0, 0, 0, 0, 0, 1, 0, 32'h0);
      go(1, 8'h80, 0, 1, 0, 0, 0, 32'h0);          // ack returns 0x45, 0x80 pends
      idle();
      go(1, 8'h80, 1, 1, 0, 0, 0, 32'h0);          // ack 0x80 while reposting 0x80
      idle();
      phase = "R10 coalesce";
      go(1, 8'h80, 0, 0, 0, 0, 0, 32'h0);          // already pending: count stays
      idle();
      phase = "R6 empty ack";
      go(0, 0, 0, 1, 0, 0, 0, 32'h0);
      go(0, 0, 0, 1, 0, 0, 0, 32'h0);
      idle();

      // constrained random
      phase = "random";
      for (int n = 0; n < 4000; n++) begin
         bit pv  = ($urandom % 100) < 45;
         bit ak  = ($urandom % 100) < 25;
         bit eo  = ($urandom % 100) < 20;
         bit twe = ($urandom % 100) < 5;
         bit swe = ($urandom % 100) < 3;
         logic [7:0] v = (($urandom % 2) == 0) ? 8'($urandom) : 8'(8'h40 + ($urandom % 8) * 8'h11);
         logic [31:0] wd = $urandom;
         if (swe && (($urandom % 4) != 0)) wd[8] = 1'b1;
         if (twe && (($urandom % 3) == 0)) wd[7:0] = 8'h0;
         go(pv, v, ($urandom % 2) == 1, ak, eo, twe, swe, wd);
      end
      idle(); idle();
      if (!done) begin
         done = 1'b1;
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      #1_000_000;
      if (!done) begin
         done = 1'b1;
         checks++;
         errors++;
         $display("FAIL watchdog expired");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule